// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

A single-level interrupt controller meant to sit next to a small 8-bit processor core. One 8-bit control/status word holds a global enable, an enable per source and a pending flag per source. There are three sources: an external line, a timer overflow and a converter-done event. Software reads this word and writes it over a simple register port. Hardware events arrive as one-cycle pulses and latch into the pending flags.

The controller considers pending work only in cycles where the core raises its phase strobe. If more than one enabled source is pending, the fixed priority picks one. The controller then sends the core a one-cycle acknowledge with the 8-bit vector address. At the same time it clears the global enable and the chosen flag, so only one routine runs at a time. A return that re-enables interrupts restores the global enable. A plain return leaves it as it is. A stack-full input holds off every acceptance.

Top module: `irq_vec_ctrl`

## Requirements
- R1: The word read on `reg_rdata` has this layout: bit 0 is the global enable, bits 1/2/3 are the external/timer/converter enables and bits 4/5/6 are the external/timer/converter pending flags, all active high. Bit 7 always reads 0.
- R2: A write with bit 7 set has no effect on bit 7, and the other bits take the written value.
- R3: When several enabled sources are pending, the external source wins with vector 0x04, then the timer with 0x08, then the converter with 0x0C.
- R4: Acceptance happens only in a cycle with `phase_stb` high. A request that becomes pending between strobes is accepted at the next strobe if its enables are set.
- R5: A pending flag stays set until it is serviced or a register write clears it. If a hardware pulse and a write hit the same flag in one cycle, the flag ends up set.
- R6: A global enable of 0 masks every source. A source enable of 0 masks only that source.
- R7: On acceptance, `irq_ack` is high for exactly the cycle after the strobe edge, with the vector on `irq_vec`. In that same update the global enable and the chosen flag clear.
- R8: A pulse on `ret_reti` sets the global enable. A pulse on `ret_plain` leaves it unchanged.
- R9: No request is accepted while `stack_full` is high.
- R10: After reset the word reads 0x00 and `irq_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control/status word |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current control/status word |
| phase_stb | input | 1 | Acceptance phase strobe from the core |
| ext_evt | input | 1 | External request pulse |
| tmr_evt | input | 1 | Timer overflow pulse |
| adc_evt | input | 1 | Converter-done pulse |
| stack_full | input | 1 | Return stack has no free entry |
| ret_reti | input | 1 | Return that re-enables interrupts |
| ret_plain | input | 1 | Return that leaves the enable alone |
| irq_ack | output | 1 | One-cycle acknowledge to the core |
| irq_vec | output | 8 | Vector address for the acknowledge |

## Verification
Directed patterns come first. All three sources are raised together to separate the priority order from arrival order. Requests are then left waiting across strobe-free cycles, which shows that acceptance is gated by the phase. Plain and re-enabling returns are compared to see which one reopens service. The stack-full line is held, and writes coincide with hardware pulses on the same flag. A long seeded random run then mixes strobes, pulses, writes that include bit 7, returns and stack-full. Every cycle is compared against a reference model, which exposes ordering errors between write, clear and set within a single update.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   localparam int unsigned SRC_EXT = 0;
   localparam int unsigned SRC_TMR = 1;
   localparam int unsigned SRC_ADC = 2;

   localparam int unsigned CTRL_MST_BIT = 0;

   function automatic int unsigned en_bit(input int unsigned src);
      return 1 + src;
   endfunction

   function automatic int unsigned fl_bit(input int unsigned src, input int unsigned nsrc);
      return 1 + nsrc + src;
   endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned NUM_SRC = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [NUM_SRC-1:0] wr_val,
   input  logic [NUM_SRC-1:0] clr_mask,
   input  logic [NUM_SRC-1:0] set_evt,
   output logic [NUM_SRC-1:0] flags
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      logic q, d;
      always_comb begin
         d = wr_en ? wr_val[i] : q;
         if (clr_mask[i]) d = 1'b0;
         if (set_evt[i])  d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= d;
      end
      assign flags[i] = q;
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned NUM_SRC    = 3,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VEC_BASE   = 4,
   parameter int unsigned VEC_STRIDE = 4
) (
   input  logic [NUM_SRC-1:0] req,
   output logic               any,
   output logic [NUM_SRC-1:0] grant,
   output logic [VEC_W-1:0]   vec
);
   logic [NUM_SRC-1:0] higher;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
      if (i == 0) begin : g_top
         assign higher[i] = 1'b0;
      end else begin : g_rest
         assign higher[i] = higher[i-1] | req[i-1];
      end
      assign grant[i] = req[i] & ~higher[i];
   end

   assign any = |req;

   always_comb begin
      vec = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (grant[i]) vec = vec | VEC_W'(VEC_BASE + i * VEC_STRIDE);
      end
   end
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
   parameter int unsigned NUM_SRC = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_mst,
   input  logic [NUM_SRC-1:0] wr_src,
   input  logic               reti,
   input  logic               accept,
   output logic               mst,
   output logic [NUM_SRC-1:0] src_en
);
   logic mst_d;

   always_comb begin
      mst_d = wr_en ? wr_mst : mst;
      if (reti)   mst_d = 1'b1;
      if (accept) mst_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst    <= 1'b0;
         src_en <= '0;
      end else begin
         mst <= mst_d;
         if (wr_en) src_en <= wr_src;
      end
   end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned NUM_SRC    = 3,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VEC_BASE   = 4,
   parameter int unsigned VEC_STRIDE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              phase_stb,
   input  logic              ext_evt,
   input  logic              tmr_evt,
   input  logic              adc_evt,
   input  logic              stack_full,
   input  logic              ret_reti,
   input  logic              ret_plain,
   output logic              irq_ack,
   output logic [VEC_W-1:0]  irq_vec
);
   localparam int unsigned EN_LSB = 1;
   localparam int unsigned FL_LSB = 1 + NUM_SRC;
   localparam int unsigned USED_W = 1 + 2 * NUM_SRC;

   if (USED_W > DATA_W) begin : g_bad_width
      $error("control word too narrow for source count");
   end
   if (NUM_SRC != 3) begin : g_bad_src
      $error("event pins exist for exactly three sources");
   end
   if (VEC_BASE + (NUM_SRC - 1) * VEC_STRIDE >= (1 << VEC_W)) begin : g_bad_vec
      $error("vector range exceeds vector width");
   end

   logic               mst;
   logic [NUM_SRC-1:0] src_en, flags, pend, grant, clr_mask, evt;
   logic               any_pend, accept;
   logic [VEC_W-1:0]   win_vec;
   logic               ack_q;
   logic [VEC_W-1:0]   vec_q;
   logic               unused_ret;

   assign evt        = {adc_evt, tmr_evt, ext_evt};
   assign pend       = flags & src_en;
   assign accept     = phase_stb & mst & ~stack_full & any_pend;
   assign clr_mask   = accept ? grant : '0;
   assign unused_ret = ret_plain;

   irq_en_reg #(.NUM_SRC(NUM_SRC)) u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_wr),
      .wr_mst (reg_wdata[irq_vec_pkg::CTRL_MST_BIT]),
      .wr_src (reg_wdata[EN_LSB +: NUM_SRC]),
      .reti   (ret_reti),
      .accept (accept),
      .mst    (mst),
      .src_en (src_en)
   );

   irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .wr_val   (reg_wdata[FL_LSB +: NUM_SRC]),
      .clr_mask (clr_mask),
      .set_evt  (evt),
      .flags    (flags)
   );

   irq_prio_pick #(
      .NUM_SRC    (NUM_SRC),
      .VEC_W      (VEC_W),
      .VEC_BASE   (VEC_BASE),
      .VEC_STRIDE (VEC_STRIDE)
   ) u_pick (
      .req   (pend),
      .any   (any_pend),
      .grant (grant),
      .vec   (win_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         vec_q <= '0;
      end else begin
         ack_q <= accept;
         if (accept) vec_q <= win_vec;
      end
   end

   always_comb begin
      reg_rdata = '0;
      reg_rdata[irq_vec_pkg::CTRL_MST_BIT] = mst;
      reg_rdata[EN_LSB +: NUM_SRC] = src_en;
      reg_rdata[FL_LSB +: NUM_SRC] = flags;
   end

   assign irq_ack = ack_q;
   assign irq_vec = vec_q;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned NUM_SRC    = 3,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VEC_BASE   = 4,
   parameter int unsigned VEC_STRIDE = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              phase_stb,
   input logic              stack_full,
   input logic              ret_reti,
   input logic              ret_plain,
   input logic              irq_ack,
   input logic [VEC_W-1:0]  irq_vec
);
   localparam int unsigned VEC_TOP = VEC_BASE + (NUM_SRC - 1) * VEC_STRIDE;

   AST_BIT7_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1] == 1'b0); // R1
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_ack); // R7
   AST_ACK_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> !reg_rdata[0]); // R7
   AST_ACK_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_ack) |-> $past(phase_stb)); // R4
   AST_NO_ACK_STACK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_ack) |-> !$past(stack_full)); // R9
   AST_ACK_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_ack) |-> $past(reg_rdata[0])); // R6
   AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (irq_vec >= VEC_W'(VEC_BASE) && irq_vec <= VEC_W'(VEC_TOP)
                   && ((irq_vec - VEC_W'(VEC_BASE)) % VEC_W'(VEC_STRIDE)) == 0)); // R3
   AST_RETI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ret_reti |=> (reg_rdata[0] || irq_ack)); // R8
   AST_RET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_plain && !ret_reti && !reg_wr) |=> (reg_rdata[0] == $past(reg_rdata[0]) || irq_ack)); // R8
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
   .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .VEC_W(VEC_W),
   .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
   .phase_stb(phase_stb), .stack_full(stack_full), .ret_reti(ret_reti),
   .ret_plain(ret_plain), .irq_ack(irq_ack), .irq_vec(irq_vec)
);

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       phase_stb = 1'b0, ext_evt = 1'b0, tmr_evt = 1'b0, adc_evt = 1'b0;
   logic       stack_full = 1'b0, ret_reti = 1'b0, ret_plain = 1'b0;
   logic       irq_ack;
   logic [7:0] irq_vec;

   int n_total = 0, n_fail = 0;
   bit done = 1'b0;
   string tag = "R10";

   bit       m_mst = 1'b0;
   bit [2:0] m_en = 3'b0, m_fl = 3'b0;
   bit       x_ack = 1'b0;
   bit [7:0] x_vec = 8'h00;

   always #10 clk = ~clk;

   irq_vec_ctrl u_irq_vec_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .phase_stb(phase_stb), .ext_evt(ext_evt),
      .tmr_evt(tmr_evt), .adc_evt(adc_evt), .stack_full(stack_full),
      .ret_reti(ret_reti), .ret_plain(ret_plain), .irq_ack(irq_ack),
      .irq_vec(irq_vec)
   );

   function automatic bit [7:0] word_of(bit mst, bit [2:0] en, bit [2:0] fl);
      return {1'b0, fl, en, mst};
   endfunction

   function automatic bit [7:0] vec_of(int idx);
      return 8'(4 + 4 * idx);
   endfunction

   task automatic check(string what, logic [7:0] act, bit [7:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic step(bit stb, bit [2:0] ev, bit full, bit wr, bit [7:0] wd,
                       bit reti, bit ret);
      bit acc;
      bit [2:0] pend;
      int win;
      @(negedge clk);
      check("word", reg_rdata, word_of(m_mst, m_en, m_fl));
      check("ack", {7'b0, irq_ack}, {7'b0, x_ack});
      if (x_ack) check("vector", irq_vec, x_vec);
      phase_stb = stb; {adc_evt, tmr_evt, ext_evt} = ev; stack_full = full;
      reg_wr = wr; reg_wdata = wd; ret_reti = reti; ret_plain = ret;
      pend = m_fl & m_en;
      acc = stb && m_mst && !full && (pend != 3'b0);
      win = pend[0] ? 0 : (pend[1] ? 1 : 2);
      if (wr) begin m_fl = wd[6:4]; m_en = wd[3:1]; m_mst = wd[0]; end
      if (reti) m_mst = 1'b1;
      if (acc) begin m_mst = 1'b0; m_fl[win] = 1'b0; x_vec = vec_of(win); end
      m_fl = m_fl | ev;
      x_ack = acc;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 3'b0, 0, 0, 8'h00, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_total++; n_fail++;
         $display("FAIL R4 watchdog expired: got hung expected finish");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tag = "R10"; idle(2);                          // reset state 0x00
      tag = "R2";  step(0, 3'b0, 0, 1, 8'h8F, 0, 0); // bit7 ignored, R1 layout
      tag = "R4";  step(0, 3'b111, 0, 0, 8'h00, 0, 0);
      idle(3);                                       // pending, no strobe, no ack
      tag = "R3";  step(1, 3'b0, 0, 0, 8'h00, 0, 0); // ext wins 0x04
      tag = "R7";  step(1, 3'b0, 0, 0, 8'h00, 0, 0); // master off, no second ack
      tag = "R8";  step(0, 3'b0, 0, 0, 8'h00, 0, 1); // plain return keeps 0
      idle(1);
      step(0, 3'b0, 0, 0, 8'h00, 1, 0);              // reti sets master
      tag = "R9";  step(1, 3'b0, 1, 0, 8'h00, 0, 0); // stack full blocks
      idle(1);
      tag = "R3";  step(1, 3'b0, 0, 0, 8'h00, 0, 0); // timer 0x08
      step(0, 3'b0, 0, 0, 8'h00, 1, 0);
      step(1, 3'b0, 0, 0, 8'h00, 0, 0);              // converter 0x0C
      idle(1);
      tag = "R5";  step(0, 3'b001, 0, 1, 8'h0E, 0, 0); // hw set beats write 0
      step(0, 3'b0, 0, 1, 8'h7E, 0, 0);              // flags stay until cleared
      idle(2);
      tag = "R6";  step(1, 3'b0, 0, 0, 8'h00, 0, 0); // master 0 masks all
      step(0, 3'b0, 0, 1, 8'h71, 0, 0);              // master on, sources off
      step(1, 3'b0, 0, 0, 8'h00, 0, 0);              // still no ack
      step(0, 3'b0, 0, 1, 8'h75, 0, 0);              // only timer enabled
      step(1, 3'b0, 0, 0, 8'h00, 0, 0);              // timer 0x08 despite ext flag
      idle(2);
      tag = "R1";
      for (int i = 0; i < 4000; i++) begin
         bit wr;
         wr = ($urandom % 10) == 0;
         step(($urandom % 4) == 0,
              {($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0},
              ($urandom % 8) == 0, wr, 8'($urandom), ($urandom % 16) == 0,
              ($urandom % 16) == 0);
      end
      idle(2);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule